// File: doc/BRIEF.md
# Multi-Threshold Weight-Update Pulse Scheduler

This block converts one signed weight-update value for an analogue synapse into a train of programming pulse commands. The absolute value of the update is located in a programmable, ascending set of up to four thresholds. The interval it falls in picks a pulse count from a matching table. The sign picks the pulse polarity: increase-conductance (set) or decrease-conductance (reset). A pseudo-random bit picks which device of the differential pair is programmed. Small updates fall in a dead zone and produce no pulse at all. The size of the update, not only its sign, decides how hard the cell is driven.

The pulses are issued one at a time, each `PULSE_CYC` clock cycles wide, with `GAP_CYC` idle cycles between them. When the train ends, a one-cycle done strobe is raised. An upstream training engine presents an averaged update with a start strobe and waits for done before it sends the next update. Thresholds, pulse counts and the number of active thresholds are written through a small register port, and only while the scheduler is idle.

Top module: `wupd_pulse_sched`

## Requirements
- R1: After reset, busy_o, done_o, pulse_set_o and pulse_rst_o are low. The configuration then holds 2 active thresholds (10, 100) and pulse counts P0=0, P1=1, P2=150.
- R2: The magnitude is |upd_i|, with upd_i in two's complement. The pulse index is the first i below the active threshold count M for which the magnitude is less than threshold i. If there is no such i, the index is M. The pulse count is P[index]. The value -2^(DATA_W-1) has magnitude 2^(DATA_W-1).
- R3: An accepted update of value zero, or one whose looked-up count is zero, issues no pulse. It raises done_o in the first cycle after the accepting edge, and busy_o stays low.
- R4: A positive update drives only pulse_set_o. A negative update drives only pulse_rst_o. The two are never high together.
- R5: The first pulse starts in the cycle after the accepting edge. Each pulse is PULSE_CYC cycles high, and consecutive pulses are separated by GAP_CYC low cycles. done_o is high for exactly one cycle, right after the last pulse, and busy_o is low in that cycle.
- R6: A 16-bit Fibonacci LFSR is seeded with 0xACE1 at reset. It shifts left, and its new bit 0 is s[15]^s[13]^s[12]^s[10]. On every accepted update, tgt_neg_o takes bit 0 of the current state and the LFSR then advances once. tgt_neg_o holds this value until the next accepted update.
- R7: start_i is ignored while busy_o is high. No second train follows, and the LFSR does not advance.
- R8: Configuration writes take effect only while busy_o is low. Address 0 sets M, and a value above 4 is stored as 4. Addresses 1..4 set thresholds 0..3. Addresses 8..12 set pulse counts P0..P4 (low 8 bits).
- R9: With M=0, every nonzero update issues P0 pulses. With P0=1, this is exactly one pulse of the sign's polarity.
- R10: Pulse counts are 8 bits wide. A count of 255 issues 255 pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Update strobe, accepted when idle |
| upd_i | input | DATA_W | Signed weight-update value |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_addr_i | input | 4 | Configuration register address |
| cfg_wdata_i | input | DATA_W | Configuration write data |
| busy_o | output | 1 | Pulse train in progress |
| done_o | output | 1 | One-cycle end-of-update strobe |
| pulse_set_o | output | 1 | Conductance-increase pulse active |
| pulse_rst_o | output | 1 | Conductance-decrease pulse active |
| tgt_neg_o | output | 1 | Selected device: 1 = negative-weight cell |

## Verification
Directed magnitudes are placed just below, exactly on and just above each default threshold. These show whether the interval comparison is strict or inclusive, and whether the dead zone is honoured. Negative values, including the most negative code, separate reset polarity from set and test the magnitude computation. Start strobes and register writes are injected in the middle of a long train; the following updates then show whether either one leaked through. Random configurations, with 0 to 4 thresholds, are mixed with random signed updates. Pulse counts, pulse and gap widths, and target bits are compared against a bench model of the lookup and the LFSR.

// File: rtl/wupd_pkg.sv
package wupd_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_PULSE, ST_GAP} sched_st_e;
  localparam int ADDR_W = 4;
  localparam int A_NTH  = 0;
  localparam int A_THR0 = 1;
  localparam int A_CNT0 = 8;
endpackage

// File: rtl/wupd_cfg_regs.sv
module wupd_cfg_regs import wupd_pkg::*; #(
  parameter int MAX_TH = 4,
  parameter int MAG_W  = 16,
  parameter int CNT_W  = 8,
  parameter int DEF_M  = 2,
  parameter logic [MAG_W-1:0] DEF_TH_LO = 10,
  parameter logic [MAG_W-1:0] DEF_TH_HI = 100,
  parameter logic [CNT_W-1:0] DEF_P_HI  = 150,
  localparam int MW = $clog2(MAX_TH + 1)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          busy_i,
  input  logic                          we_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [MAG_W-1:0]              wdata_i,
  output logic [MW-1:0]                 m_o,
  output logic [MAX_TH-1:0][MAG_W-1:0]  thr_o,
  output logic [MAX_TH:0][CNT_W-1:0]    cnt_o
);
  logic wr_ok;
  logic [MW-1:0] m_q;
  logic [MAX_TH-1:0][MAG_W-1:0] thr_q;
  logic [MAX_TH:0][CNT_W-1:0] cnt_q;

  assign wr_ok = we_i && !busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) m_q <= MW'(DEF_M);
    else if (wr_ok && addr_i == ADDR_W'(A_NTH))
      m_q <= (wdata_i > MAG_W'(MAX_TH)) ? MW'(MAX_TH) : wdata_i[MW-1:0];
  end

  for (genvar g = 0; g < MAX_TH; g++) begin : g_thr
    localparam logic [MAG_W-1:0] RST_TH = (g == 0) ? DEF_TH_LO : (g == 1) ? DEF_TH_HI : '1;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) thr_q[g] <= RST_TH;
      else if (wr_ok && addr_i == ADDR_W'(A_THR0 + g)) thr_q[g] <= wdata_i;
    end
  end

  for (genvar g = 0; g <= MAX_TH; g++) begin : g_cnt
    localparam logic [CNT_W-1:0] RST_CNT = (g == 1) ? CNT_W'(1) : (g == 2) ? DEF_P_HI : '0;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cnt_q[g] <= RST_CNT;
      else if (wr_ok && addr_i == ADDR_W'(A_CNT0 + g)) cnt_q[g] <= wdata_i[CNT_W-1:0];
    end
  end

  assign m_o   = m_q;
  assign thr_o = thr_q;
  assign cnt_o = cnt_q;

  a_r8_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> ($stable(m_q) && $stable(thr_q) && $stable(cnt_q)));
  a_r8_m_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_q <= MW'(MAX_TH));
endmodule

// File: rtl/wupd_interval_lut.sv
module wupd_interval_lut #(
  parameter int MAX_TH = 4,
  parameter int MAG_W  = 16,
  parameter int CNT_W  = 8,
  localparam int MW = $clog2(MAX_TH + 1)
) (
  input  logic [MAG_W-1:0]              mag_i,
  input  logic [MW-1:0]                 m_i,
  input  logic [MAX_TH-1:0][MAG_W-1:0]  thr_i,
  input  logic [MAX_TH:0][CNT_W-1:0]    cnt_i,
  output logic [MW-1:0]                 idx_o,
  output logic [CNT_W-1:0]              cnt_o
);
  logic found;

  // first active threshold the magnitude stays below
  always_comb begin
    found = 1'b0;
    idx_o = m_i;
    for (int i = 0; i < MAX_TH; i++) begin
      if (!found && (MW'(i) < m_i) && (mag_i < thr_i[i])) begin
        idx_o = MW'(i);
        found = 1'b1;
      end
    end
    cnt_o = cnt_i[idx_o];
  end
endmodule

// File: rtl/wupd_lfsr.sv
module wupd_lfsr #(
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic adv_i,
  output logic bit_o
);
  logic [15:0] state_q;
  logic fb;

  assign fb    = state_q[15] ^ state_q[13] ^ state_q[12] ^ state_q[10];
  assign bit_o = state_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    state_q <= SEED;
    else if (adv_i) state_q <= {state_q[14:0], fb};
  end

  a_r6_lfsr_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != '0);
  a_r6_lfsr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(state_q));
endmodule

// File: rtl/wupd_pulse_sched.sv
module wupd_pulse_sched import wupd_pkg::*; #(
  parameter int DATA_W    = 16,
  parameter int MAX_TH    = 4,
  parameter int CNT_W     = 8,
  parameter int PULSE_CYC = 3,
  parameter int GAP_CYC   = 2,
  parameter int DEF_M     = 2,
  parameter logic [DATA_W-1:0] DEF_TH_LO = 10,
  parameter logic [DATA_W-1:0] DEF_TH_HI = 100,
  parameter logic [CNT_W-1:0]  DEF_P_HI  = 150,
  parameter logic [15:0]       LFSR_SEED = 16'hACE1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] upd_i,
  input  logic              cfg_we_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              pulse_set_o,
  output logic              pulse_rst_o,
  output logic              tgt_neg_o
);
  localparam int MW      = $clog2(MAX_TH + 1);
  localparam int TMR_MAX = (PULSE_CYC > GAP_CYC) ? PULSE_CYC : GAP_CYC;
  localparam int TMR_W   = (TMR_MAX > 1) ? $clog2(TMR_MAX) : 1;

  if (PULSE_CYC < 1 || GAP_CYC < 1 || MAX_TH < 1 || MAX_TH > 7) begin : g_bad_param
    $error("wupd_pulse_sched: unsupported timing or threshold parameters");
  end

  sched_st_e state_q;
  logic [CNT_W-1:0] remain_q;
  logic [TMR_W-1:0] tmr_q;
  logic set_q, tgt_q, done_q;

  logic [DATA_W-1:0] mag;
  logic [MW-1:0] m_w, idx_w;
  logic [MAX_TH-1:0][DATA_W-1:0] thr_w;
  logic [MAX_TH:0][CNT_W-1:0] cnt_w;
  logic [CNT_W-1:0] cnt_sel;
  logic lfsr_bit, accept, busy;

  assign busy   = (state_q != ST_IDLE);
  assign accept = start_i && !busy;
  assign mag    = upd_i[DATA_W-1] ? (~upd_i + 1'b1) : upd_i;

  wupd_cfg_regs #(
    .MAX_TH(MAX_TH), .MAG_W(DATA_W), .CNT_W(CNT_W), .DEF_M(DEF_M),
    .DEF_TH_LO(DEF_TH_LO), .DEF_TH_HI(DEF_TH_HI), .DEF_P_HI(DEF_P_HI)
  ) u_cfg (
    .clk_i, .rst_ni, .busy_i(busy), .we_i(cfg_we_i), .addr_i(cfg_addr_i),
    .wdata_i(cfg_wdata_i), .m_o(m_w), .thr_o(thr_w), .cnt_o(cnt_w)
  );

  wupd_interval_lut #(.MAX_TH(MAX_TH), .MAG_W(DATA_W), .CNT_W(CNT_W)) u_lut (
    .mag_i(mag), .m_i(m_w), .thr_i(thr_w), .cnt_i(cnt_w), .idx_o(idx_w), .cnt_o(cnt_sel)
  );

  wupd_lfsr #(.SEED(LFSR_SEED)) u_lfsr (
    .clk_i, .rst_ni, .adv_i(accept), .bit_o(lfsr_bit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      remain_q <= '0;
      tmr_q    <= '0;
      set_q    <= 1'b0;
      tgt_q    <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          set_q <= !upd_i[DATA_W-1];
          tgt_q <= lfsr_bit;
          if (mag == '0 || cnt_sel == '0) begin
            done_q <= 1'b1;
          end else begin
            state_q  <= ST_PULSE;
            remain_q <= cnt_sel;
            tmr_q    <= TMR_W'(PULSE_CYC - 1);
          end
        end
        ST_PULSE: begin
          if (tmr_q == '0) begin
            remain_q <= remain_q - 1'b1;
            if (remain_q == CNT_W'(1)) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end else begin
              state_q <= ST_GAP;
              tmr_q   <= TMR_W'(GAP_CYC - 1);
            end
          end else begin
            tmr_q <= tmr_q - 1'b1;
          end
        end
        ST_GAP: begin
          if (tmr_q == '0) begin
            state_q <= ST_PULSE;
            tmr_q   <= TMR_W'(PULSE_CYC - 1);
          end else begin
            tmr_q <= tmr_q - 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = busy;
  assign done_o      = done_q;
  assign pulse_set_o = (state_q == ST_PULSE) && set_q;
  assign pulse_rst_o = (state_q == ST_PULSE) && !set_q;
  assign tgt_neg_o   = tgt_q;

  a_r4_one_polarity: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pulse_set_o && pulse_rst_o));
  a_r5_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  a_r5_remain_nz: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (remain_q != '0));
  a_r6_tgt_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(tgt_neg_o));
  a_r3_zero_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && upd_i == '0) |=> (done_o && !busy_o));
  a_r2_idx_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_w <= m_w);
endmodule

// File: tb/wupd_pulse_sched_tb_top.sv
module wupd_pulse_sched_tb_top;
  localparam int PW = 3;
  localparam int GW = 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [15:0] upd_i = '0;
  logic cfg_we_i = 1'b0;
  logic [3:0] cfg_addr_i = '0;
  logic [15:0] cfg_wdata_i = '0;
  logic busy_o, done_o, pulse_set_o, pulse_rst_o, tgt_neg_o;

  always #10 clk = ~clk;

  wupd_pulse_sched #(.PULSE_CYC(PW), .GAP_CYC(GW)) dut_i (
    .clk_i(clk), .rst_ni, .start_i, .upd_i, .cfg_we_i, .cfg_addr_i, .cfg_wdata_i,
    .busy_o, .done_o, .pulse_set_o, .pulse_rst_o, .tgt_neg_o
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  int m_m;
  int m_thr[4];
  int m_cnt[5];
  logic [15:0] m_lfsr;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_cnt(input int mag);
    int idx = m_m;
    if (mag == 0) return 0;
    for (int i = 0; i < m_m; i++) if (mag < m_thr[i]) begin idx = i; break; end
    return m_cnt[idx];
  endfunction

  task automatic cfg_wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_we_i = 1'b1; cfg_addr_i = a; cfg_wdata_i = d;
    @(negedge clk);
    cfg_we_i = 1'b0;
    if (a == 0) m_m = (d > 4) ? 4 : int'(d);
    else if (a >= 1 && a <= 4) m_thr[a-1] = int'(d);
    else if (a >= 8 && a <= 12) m_cnt[a-8] = int'(d[7:0]);
  endtask

  task automatic run_upd(input logic signed [15:0] u, input bit poke_start,
                         input bit poke_cfg, input string req);
    int mag, e, np, run, gap, samples, bad_w, bad_gap, bad_pol, bad_both;
    bit etgt, eset, first_hi, dseen;
    mag  = (u < 0) ? -int'(u) : int'(u);
    e    = exp_cnt(mag);
    eset = (u > 0);
    etgt = m_lfsr[0];
    m_lfsr = {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
    np = 0; run = 0; gap = 0; samples = 0;
    bad_w = 0; bad_gap = 0; bad_pol = 0; bad_both = 0;
    @(negedge clk);
    start_i = 1'b1; upd_i = u;
    @(negedge clk);
    start_i = 1'b0;
    first_hi = pulse_set_o | pulse_rst_o;
    dseen = 1'b0;
    while (samples < 3000) begin
      if (done_o) begin dseen = 1'b1; break; end
      if (pulse_set_o && pulse_rst_o) bad_both++;
      if (pulse_set_o || pulse_rst_o) begin
        if (pulse_set_o != eset) bad_pol++;
        if (run == 0 && np > 0 && gap != GW) bad_gap++;
        run++;
      end else begin
        if (run > 0) begin
          if (run != PW) bad_w++;
          np++; run = 0; gap = 0;
        end
        gap++;
      end
      if (poke_start && samples == 3) begin start_i = 1'b1; upd_i = 16'sd7; end
      if (poke_start && samples == 4) start_i = 1'b0;
      if (poke_cfg && samples == 5) begin cfg_we_i = 1'b1; cfg_addr_i = 4'd1; cfg_wdata_i = 16'd500; end
      if (poke_cfg && samples == 6) cfg_we_i = 1'b0;
      @(negedge clk);
      samples++;
    end
    if (run > 0) begin
      if (run != PW) bad_w++;
      np++;
    end
    chk(dseen, "R5 done raised", int'(dseen), 1);
    chk(np == e, req, np, e);
    chk(bad_w == 0, "R5 pulse width", bad_w, 0);
    chk(bad_gap == 0, "R5 gap width", bad_gap, 0);
    chk(bad_pol == 0 && bad_both == 0, "R4 polarity", bad_pol + bad_both, 0);
    chk(tgt_neg_o == etgt, "R6 target bit", int'(tgt_neg_o), int'(etgt));
    chk(!busy_o, "R5 idle at done", int'(busy_o), 0);
    if (e > 0) chk(first_hi, "R5 first pulse timing", int'(first_hi), 1);
    else chk(samples == 0, "R3 done latency", samples, 0);
    @(negedge clk);
    chk(!done_o && !busy_o, "R5 R7 single done, no extra train", int'({done_o, busy_o}), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int unsigned sd;
    sd = $urandom(32'd2024);
    m_m = 2; m_thr = '{10, 100, 65535, 65535}; m_cnt = '{0, 1, 150, 0, 0};
    m_lfsr = 16'hACE1;
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o && !pulse_set_o && !pulse_rst_o, "R1 reset outputs",
        int'({busy_o, done_o, pulse_set_o, pulse_rst_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(!busy_o && !done_o, "R1 idle after reset", int'({busy_o, done_o}), 0);

    // R1 R2 default intervals and edges
    run_upd(16'sd9,   0, 0, "R1 R2 below low threshold");
    run_upd(16'sd10,  0, 0, "R1 R2 on low threshold");
    run_upd(16'sd99,  0, 0, "R2 below high threshold");
    run_upd(16'sd100, 0, 0, "R1 R2 on high threshold");
    run_upd(-16'sd37, 0, 0, "R4 R2 negative single");
    run_upd(-16'sd32768, 0, 0, "R2 most negative code");
    run_upd(16'sd0,   0, 0, "R3 zero update");
    // R7 start while busy, R8 write while busy
    run_upd(16'sd120, 1, 1, "R7 R8 long train with pokes");
    run_upd(16'sd50,  0, 0, "R8 threshold write while busy ignored");
    // R8 clamp of threshold count
    cfg_wr(4'd0, 16'd7);
    cfg_wr(4'd1, 16'd10); cfg_wr(4'd2, 16'd20); cfg_wr(4'd3, 16'd30); cfg_wr(4'd4, 16'd40);
    for (int i = 0; i < 5; i++) cfg_wr(4'(8 + i), 16'(i));
    run_upd(16'sd45,  0, 0, "R8 clamp top interval");
    run_upd(-16'sd35, 0, 0, "R8 interval three");
    run_upd(16'sd5,   0, 0, "R3 dead zone");
    // R9 no thresholds
    cfg_wr(4'd0, 16'd0); cfg_wr(4'd8, 16'd1);
    run_upd(16'sd3,    0, 0, "R9 single pulse positive");
    run_upd(-16'sd200, 0, 0, "R9 single pulse negative");
    run_upd(16'sd0,    0, 0, "R9 R3 zero update");
    // R10 full 8-bit count
    cfg_wr(4'd0, 16'd1); cfg_wr(4'd1, 16'd1); cfg_wr(4'd9, 16'd255);
    run_upd(16'sd5, 0, 0, "R10 count 255");

    for (int c = 0; c < 8; c++) begin
      int t = 0;
      cfg_wr(4'd0, 16'($urandom_range(0, 4)));
      for (int i = 0; i < 4; i++) begin
        t += $urandom_range(1, 60);
        cfg_wr(4'(1 + i), 16'(t));
      end
      for (int i = 0; i < 5; i++) cfg_wr(4'(8 + i), 16'($urandom_range(0, 12)));
      for (int k = 0; k < 8; k++) begin
        int mg = ($urandom_range(0, 7) == 0) ? 0 : int'($urandom_range(0, 300));
        logic signed [15:0] u = $urandom_range(0, 1) ? -16'(mg) : 16'(mg);
        run_upd(u, 0, 0, "R2 random interval");
      end
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule